// File: doc/BRIEF.md
# Continuous-Fill Nine-Bit Serial Link

This block is a serial transmitter and receiver pair for a line that must keep toggling at all times. Each frame carries nine data bits. The top bit marks a frame as payload (1) or filler (0). The transmitter takes bytes from an eight-entry queue. At every frame boundary where that queue is empty, it sends the filler pattern 0xAA with the marker bit low instead of letting the line rest high.

The receiver always runs in a marker-filter mode. A frame whose marker bit is low is dropped without any trace, so filler never reaches the receive queue and never touches a status flag. A marked frame is stored together with its own frame-error bit. Sticky flags record framing faults and bytes lost to a full receive queue, and a one-cycle clear input resets them. Bit timing comes from a divisor input on a 16-times oversampling clock enable. A configuration input selects one or two stop bits.

Top module: `ufill_link`

## Requirements
- R1: While reset is held and after it is released, `txd_o` is high until the first frame begins. Both queues report empty, and both sticky flags read 0.
- R2: A 16x enable pulses once every `div_i`+1 clock cycles. Every serial bit lasts 16 such pulses, which is 16*(`div_i`+1) clock cycles.
- R3: A frame has the following parts, in order: a start bit at 0, data bits 0 to 7 with the least significant bit first, the marker bit, and then one stop bit at 1 (`two_stop_i`=0) or two stop bits at 1 (`two_stop_i`=1). Frames follow each other with no idle time between them.
- R4: When the transmit queue is not empty at a frame boundary, the transmitter pops one byte and sends it with the marker bit at 1. Bytes leave in the order they were pushed.
- R5: When the transmit queue is empty at a frame boundary, the transmitter sends 0xAA with the marker bit at 0. The longest high run on `txd_o` then equals the stop length, which is 16 or 32 sub-ticks.
- R6: A received frame whose marker bit is 0 is discarded. It writes nothing to the receive queue and sets no flag, even if its stop bit is bad.
- R7: A received frame whose marker bit is 1 is pushed to the receive queue. Its byte appears on `rx_data_o` and its frame-error bit appears on `rx_ferr_o` while the entry is at the head of the queue.
- R8: If any stop bit of a marked frame is sampled as 0, that frame's stored error bit is 1 and the sticky `err_frame_o` flag is set. With `two_stop_i`=1, both stop bits are checked.
- R9: The receiver samples each bit at sub-tick 7 of 16. A falling edge whose start bit reads 1 at that point is treated as a glitch. The receiver then stays idle and is ready for the next real frame.
- R10: A marked frame that arrives while the receive queue is full is dropped and sets the sticky `err_ovr_o` flag. The entries already in the queue are left unchanged.
- R11: A one-cycle pulse on `err_clr_i` clears both sticky flags by the next clock cycle, unless a new fault arrives in the same cycle.
- R12: Each queue holds 8 entries. Its full output is 1 when it holds 8 entries. Its empty output is 1 when it holds 0 entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_i | input | 12 | Divisor: the 16x enable period is div_i+1 clocks |
| two_stop_i | input | 1 | 1 selects two stop bits |
| tx_push_i | input | 1 | Writes tx_data_i into the transmit queue |
| tx_data_i | input | 8 | Byte to transmit |
| tx_full_o | output | 1 | Transmit queue is full |
| tx_empty_o | output | 1 | Transmit queue is empty |
| rx_pop_i | input | 1 | Removes the head entry of the receive queue |
| rx_data_o | output | 8 | Head byte of the receive queue |
| rx_ferr_o | output | 1 | Frame-error bit stored with the head byte |
| rx_full_o | output | 1 | Receive queue is full |
| rx_empty_o | output | 1 | Receive queue is empty |
| txd_o | output | 1 | Serial output line |
| rxd_i | input | 1 | Serial input line |
| err_clr_i | input | 1 | Clears both sticky flags |
| err_frame_o | output | 1 | Sticky flag: a stop bit failed in a marked frame |
| err_ovr_o | output | 1 | Sticky flag: a marked byte was lost to a full queue |

## Verification
A queued byte starts on the line at the next frame boundary, which comes at most one frame time after the push. It reaches the receive queue two synchroniser cycles after the middle sample of its last stop bit. For this reason, loopback checks poll `rx_empty_o` against a bound of a few frame times instead of checking one exact cycle. Frames driven directly by the bench end with two extra bit times of idle line before the queue and flags are read. That margin always covers the 8-sub-tick sampling offset plus synchronisation. Line timing is checked by counting the clock cycles in low and high runs of `txd_o`, sampled on the falling clock edge. The sticky flags and queue status are read one cycle after a push, pop or clear pulse.

// File: rtl/ufill_pkg.sv
package ufill_pkg;
    localparam int BYTE_W   = 8;
    localparam int OVS      = 16;
    localparam int SUB_W    = $clog2(OVS);
    localparam int MID_SUB  = OVS / 2 - 1;
    localparam logic [BYTE_W-1:0] FILL_PATTERN = 8'hAA;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_BITS  = 2'd2
    } rx_state_e;

    typedef struct packed {
        logic err_frame;
        logic err_ovr;
    } sticky_t;
endpackage

// File: rtl/ufill_fifo.sv
module ufill_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic [W-1:0] data_i,
    input  logic         pop_i,
    output logic [W-1:0] head_o,
    output logic         full_o,
    output logic         empty_o
);
    localparam int AW = $clog2(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW:0]             wr;
        logic [AW:0]             rd;
    } fifo_st_t;

    fifo_st_t q, d;
    logic do_push, do_pop;

    assign full_o  = (q.wr[AW] != q.rd[AW]) && (q.wr[AW-1:0] == q.rd[AW-1:0]);
    assign empty_o = (q.wr == q.rd);
    assign head_o  = q.mem[q.rd[AW-1:0]];

    always_comb begin
        d       = q;
        do_push = push_i && !full_o;
        do_pop  = pop_i && !empty_o;
        if (do_push) begin
            d.mem[q.wr[AW-1:0]] = data_i;
            d.wr = q.wr + (AW+1)'(1);
        end
        if (do_pop) begin
            d.rd = q.rd + (AW+1)'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.mem <= '0;
            q.wr  <= '0;
            q.rd  <= '0;
        end else begin
            q <= d;
        end
    end

    // R12
    fifo_full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && full_o && !pop_i) |=> full_o);
    // R12
    fifo_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && full_o && !push_i) |=> (!full_o && !empty_o));
endmodule

// File: rtl/ufill_baud.sv
module ufill_baud #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } baud_st_t;

    baud_st_t q, d;

    assign tick_o = (q.cnt >= div_i);

    always_comb begin
        d = q;
        if (tick_o) d.cnt = '0;
        else        d.cnt = q.cnt + DIV_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R2
    baud_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && div_i != '0) |=> (!tick_o || div_i != $past(div_i)));
endmodule

// File: rtl/ufill_tx.sv
module ufill_tx
    import ufill_pkg::*;
#(
    parameter logic [BYTE_W-1:0] FILL = FILL_PATTERN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              two_stop_i,
    input  logic              fifo_empty_i,
    input  logic [BYTE_W-1:0] fifo_data_i,
    output logic              fifo_pop_o,
    output logic              txd_o
);
    localparam int FRM_W = BYTE_W + 4;
    localparam int CNT_W = $clog2(FRM_W + 1);
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);

    typedef struct packed {
        logic             started;
        logic [SUB_W-1:0] sub;
        logic [CNT_W-1:0] bitn;
        logic [FRM_W-1:0] sh;
    } tx_st_t;

    tx_st_t q, d;
    logic [CNT_W-1:0] last_idx;
    logic             load;

    assign txd_o = q.sh[0];

    always_comb begin
        d          = q;
        fifo_pop_o = 1'b0;
        last_idx   = two_stop_i ? CNT_W'(FRM_W - 1) : CNT_W'(FRM_W - 2);
        load       = tick_i && (!q.started || (q.sub == SUB_LAST && q.bitn >= last_idx));
        if (load) begin
            d.started = 1'b1;
            d.sub     = '0;
            d.bitn    = '0;
            if (!fifo_empty_i) begin
                fifo_pop_o = 1'b1;
                d.sh = {2'b11, 1'b1, fifo_data_i, 1'b0};
            end else begin
                d.sh = {2'b11, 1'b0, FILL, 1'b0};
            end
        end else if (tick_i) begin
            d.sub = q.sub + SUB_W'(1);
            if (q.sub == SUB_LAST) begin
                d.sh   = {1'b1, q.sh[FRM_W-1:1]};
                d.bitn = q.bitn + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.started <= 1'b0;
            q.sub     <= '0;
            q.bitn    <= '0;
            q.sh      <= '1;
        end else begin
            q <= d;
        end
    end

    // R4
    tx_pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop_o |-> !fifo_empty_i);
    // R1
    tx_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !q.started |-> txd_o);
    // R3
    tx_start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !txd_o);
endmodule

// File: rtl/ufill_rx.sv
module ufill_rx
    import ufill_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_i,
    input  logic            two_stop_i,
    input  logic            rxd_i,
    input  logic            fifo_full_i,
    output logic            push_o,
    output logic [BYTE_W:0] push_data_o,
    output logic            ferr_set_o,
    output logic            ovr_set_o
);
    localparam int CNT_W = $clog2(BYTE_W + 4);
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);
    localparam logic [SUB_W-1:0] SUB_MID  = SUB_W'(MID_SUB);

    typedef struct packed {
        logic [1:0]       sync;
        rx_state_e        st;
        logic [SUB_W-1:0] sub;
        logic [CNT_W-1:0] cnt;
        logic [BYTE_W:0]  sh;
        logic             ferr;
    } rx_st_t;

    rx_st_t q, d;
    logic             rx_s;
    logic [CNT_W-1:0] last_cnt;
    logic             fe;

    assign rx_s = q.sync[1];

    always_comb begin
        d           = q;
        d.sync      = {q.sync[0], rxd_i};
        push_o      = 1'b0;
        ferr_set_o  = 1'b0;
        ovr_set_o   = 1'b0;
        last_cnt    = two_stop_i ? CNT_W'(BYTE_W + 2) : CNT_W'(BYTE_W + 1);
        fe          = q.ferr | ~rx_s;
        push_data_o = {fe, q.sh[BYTE_W-1:0]};
        unique case (q.st)
            RX_IDLE: begin
                if (tick_i && !rx_s) begin
                    d.st  = RX_START;
                    d.sub = '0;
                end
            end
            RX_START: begin
                if (tick_i) begin
                    d.sub = q.sub + SUB_W'(1);
                    if (q.sub == SUB_MID && rx_s) begin
                        d.st = RX_IDLE;
                    end else if (q.sub == SUB_LAST) begin
                        d.st   = RX_BITS;
                        d.sub  = '0;
                        d.cnt  = '0;
                        d.ferr = 1'b0;
                    end
                end
            end
            RX_BITS: begin
                if (tick_i) begin
                    d.sub = q.sub + SUB_W'(1);
                    if (q.sub == SUB_MID) begin
                        d.cnt = q.cnt + CNT_W'(1);
                        if (q.cnt < CNT_W'(BYTE_W + 1)) begin
                            d.sh = {rx_s, q.sh[BYTE_W:1]};
                        end else begin
                            d.ferr = fe;
                        end
                        if (q.cnt >= last_cnt) begin
                            d.st = RX_IDLE;
                            if (q.sh[BYTE_W]) begin
                                ferr_set_o = fe;
                                if (fifo_full_i) ovr_set_o = 1'b1;
                                else             push_o    = 1'b1;
                            end
                        end
                    end
                end
            end
            default: d.st = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.sync <= 2'b11;
            q.st   <= RX_IDLE;
            q.sub  <= '0;
            q.cnt  <= '0;
            q.sh   <= '0;
            q.ferr <= 1'b0;
        end else begin
            q <= d;
        end
    end

    // R10
    rx_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_o |-> !fifo_full_i);
    // R7
    rx_back_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_o || ovr_set_o) |=> (q.st == RX_IDLE));
    // R6
    rx_one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(push_o && ovr_set_o));
endmodule

// File: rtl/ufill_link.sv
module ufill_link
    import ufill_pkg::*;
#(
    parameter int DIV_W      = 12,
    parameter int FIFO_DEPTH = 8,
    parameter logic [BYTE_W-1:0] FILL = FILL_PATTERN
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_i,
    input  logic             two_stop_i,
    input  logic             tx_push_i,
    input  logic [7:0]       tx_data_i,
    output logic             tx_full_o,
    output logic             tx_empty_o,
    input  logic             rx_pop_i,
    output logic [7:0]       rx_data_o,
    output logic             rx_ferr_o,
    output logic             rx_full_o,
    output logic             rx_empty_o,
    output logic             txd_o,
    input  logic             rxd_i,
    input  logic             err_clr_i,
    output logic             err_frame_o,
    output logic             err_ovr_o
);
    localparam int RX_W = BYTE_W + 1;

    logic              tick;
    logic              tx_pop;
    logic [BYTE_W-1:0] tx_head;
    logic              rx_push;
    logic [RX_W-1:0]   rx_entry;
    logic [RX_W-1:0]   rx_head;
    logic              ferr_set;
    logic              ovr_set;

    sticky_t q, d;

    ufill_baud #(.DIV_W(DIV_W)) u_baud (
        .clk    (clk),
        .rst_n  (rst_n),
        .div_i  (div_i),
        .tick_o (tick)
    );

    ufill_fifo #(.W(BYTE_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (tx_push_i),
        .data_i  (tx_data_i),
        .pop_i   (tx_pop),
        .head_o  (tx_head),
        .full_o  (tx_full_o),
        .empty_o (tx_empty_o)
    );

    ufill_tx #(.FILL(FILL)) u_tx (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick),
        .two_stop_i   (two_stop_i),
        .fifo_empty_i (tx_empty_o),
        .fifo_data_i  (tx_head),
        .fifo_pop_o   (tx_pop),
        .txd_o        (txd_o)
    );

    ufill_rx u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick),
        .two_stop_i  (two_stop_i),
        .rxd_i       (rxd_i),
        .fifo_full_i (rx_full_o),
        .push_o      (rx_push),
        .push_data_o (rx_entry),
        .ferr_set_o  (ferr_set),
        .ovr_set_o   (ovr_set)
    );

    ufill_fifo #(.W(RX_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (rx_push),
        .data_i  (rx_entry),
        .pop_i   (rx_pop_i),
        .head_o  (rx_head),
        .full_o  (rx_full_o),
        .empty_o (rx_empty_o)
    );

    assign rx_data_o   = rx_head[BYTE_W-1:0];
    assign rx_ferr_o   = rx_head[BYTE_W];
    assign err_frame_o = q.err_frame;
    assign err_ovr_o   = q.err_ovr;

    always_comb begin
        d           = q;
        d.err_frame = (q.err_frame && !err_clr_i) || ferr_set;
        d.err_ovr   = (q.err_ovr && !err_clr_i) || ovr_set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R11
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr_i && !ferr_set && !ovr_set) |=> (!err_frame_o && !err_ovr_o));
    // R10
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_ovr_o && !err_clr_i) |=> err_ovr_o);
    // R10
    ovr_keeps_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_set && !rx_pop_i) |=> rx_full_o);
endmodule

// File: tb/tb_ufill_link.sv
module tb_ufill_link;
    localparam int CLK_PERIOD = 10;
    localparam int BIT_CYC = 16;
    localparam logic [8:0] VEC [8] = '{9'h000, 9'h0FF, 9'h055, 9'h0AA,
                                      9'h001, 9'h080, 9'h03C, 9'h0C3};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] div = '0;
    logic        two_stop = 1'b0;
    logic        tx_push = 1'b0;
    logic [7:0]  tx_data = '0;
    logic        rx_pop = 1'b0;
    logic        err_clr = 1'b0;
    logic        loop_en = 1'b1;
    logic        bench_rxd = 1'b1;
    logic        tx_full, tx_empty, rx_ferr, rx_full, rx_empty, txd, err_frame, err_ovr;
    logic [7:0]  rx_data;
    logic        rxd;
    int          n_chk = 0;
    int          n_bad = 0;

    assign rxd = loop_en ? txd : bench_rxd;
    always #(CLK_PERIOD/2) clk = ~clk;

    ufill_link dut (
        .clk(clk), .rst_n(rst_n), .div_i(div), .two_stop_i(two_stop),
        .tx_push_i(tx_push), .tx_data_i(tx_data), .tx_full_o(tx_full), .tx_empty_o(tx_empty),
        .rx_pop_i(rx_pop), .rx_data_o(rx_data), .rx_ferr_o(rx_ferr), .rx_full_o(rx_full),
        .rx_empty_o(rx_empty), .txd_o(txd), .rxd_i(rxd), .err_clr_i(err_clr),
        .err_frame_o(err_frame), .err_ovr_o(err_ovr)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input int dv, input bit ts, input bit lp);
        @(negedge clk);
        rst_n = 1'b0; div = 12'(dv); two_stop = ts; loop_en = lp; bench_rxd = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic push_byte(input logic [7:0] b);
        @(negedge clk); tx_push = 1'b1; tx_data = b;
        @(negedge clk); tx_push = 1'b0;
    endtask

    task automatic pop_one();
        rx_pop = 1'b1; @(negedge clk); rx_pop = 1'b0;
    endtask

    task automatic wait_rx(input int lim, output bit got);
        got = 1'b0;
        for (int i = 0; i < lim && !got; i++) begin
            @(negedge clk);
            if (!rx_empty) got = 1'b1;
        end
    endtask

    task automatic low_run(output int len);
        len = 0;
        while (txd) @(negedge clk);
        while (!txd) begin len++; @(negedge clk); end
    endtask

    task automatic max_high(input int win, output int mx);
        int run;
        mx = 0; run = 0;
        while (txd) @(negedge clk);
        for (int i = 0; i < win; i++) begin
            @(negedge clk);
            if (txd) run++;
            else begin
                if (run > mx) mx = run;
                run = 0;
            end
        end
    endtask

    task automatic send_frame(input logic [7:0] b, input bit mark, input bit s1, input bit s2, input bit use2);
        logic [12:0] bits;
        int nb;
        bits = {s2, s1, mark, b, 1'b0};
        nb = use2 ? 13 : 12;
        for (int i = 0; i < nb - 1; i++) begin
            bench_rxd = bits[i];
            repeat (BIT_CYC) @(negedge clk);
        end
        bench_rxd = 1'b1;
        repeat (2 * BIT_CYC) @(negedge clk);
    endtask

    task automatic clear_flags();
        err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int  len, mx;
        bit  got;
        // Phase A: reset state and bit timing with divisor 2
        do_reset(2, 1'b0, 1'b1);
        chk("R1 txd idle", int'(txd), 1);
        chk("R1 tx empty", int'(tx_empty), 1);
        chk("R1 rx empty", int'(rx_empty), 1);
        chk("R1 flags", int'({err_frame, err_ovr}), 0);
        low_run(len);
        chk("R2 start+d0 of filler low run", len, 2 * 16 * 3);
        repeat (3 * 11 * 48) @(negedge clk);
        chk("R6 filler not received", int'(rx_empty), 1);
        chk("R6 filler sets no flag", int'({err_frame, err_ovr}), 0);

        // Phase B: two stop bits, loopback
        do_reset(0, 1'b1, 1'b1);
        max_high(600, mx);
        chk("R5 longest high run two stops", mx, 32);
        push_byte(8'h5C);
        wait_rx(1000, got);
        chk("R3 two-stop byte arrived", int'(got), 1);
        chk("R3 two-stop byte value", int'(rx_data), 'h5C);
        chk("R3 two-stop byte no ferr", int'(rx_ferr), 0);
        pop_one();

        // Phase C: one stop bit, table of loopback vectors
        do_reset(0, 1'b0, 1'b1);
        max_high(600, mx);
        chk("R5 longest high run one stop", mx, 16);
        foreach (VEC[i]) begin
            push_byte(VEC[i][7:0]);
            wait_rx(1000, got);
            chk("R4 vector arrived", int'(got), 1);
            chk("R7 vector data", int'(rx_data), int'(VEC[i][7:0]));
            chk("R7 vector ferr", int'(rx_ferr), int'(VEC[i][8]));
            pop_one();
        end
        // R12 / R4: fill TX queue right after a line edge, then check ordering
        while (txd) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            tx_push = 1'b1; tx_data = 8'(8'h10 + i); @(negedge clk);
        end
        tx_push = 1'b0;
        chk("R12 tx full after 8", int'(tx_full), 1);
        for (int i = 0; i < 3000 && !rx_full; i++) @(negedge clk);
        chk("R12 rx full after 8", int'(rx_full), 1);
        for (int i = 0; i < 8; i++) begin
            chk("R4 order", int'(rx_data), 'h10 + i);
            pop_one();
        end
        chk("R12 rx empty after drain", int'(rx_empty), 1);

        // Phase D: bench-driven line
        do_reset(0, 1'b0, 1'b0);
        repeat (10) @(negedge clk);
        send_frame(8'h77, 1'b0, 1'b1, 1'b1, 1'b0);
        chk("R6 unmarked frame dropped", int'(rx_empty), 1);
        send_frame(8'h78, 1'b0, 1'b0, 1'b1, 1'b0);
        chk("R6 unmarked bad stop no flag", int'(err_frame), 0);
        chk("R6 unmarked bad stop dropped", int'(rx_empty), 1);
        bench_rxd = 1'b0; repeat (4) @(negedge clk); bench_rxd = 1'b1;
        repeat (64) @(negedge clk);
        chk("R9 glitch rejected", int'(rx_empty), 1);
        send_frame(8'h96, 1'b1, 1'b1, 1'b1, 1'b0);
        chk("R9 frame after glitch", int'(rx_data), 'h96);
        chk("R7 marked frame stored", int'(rx_empty), 0);
        pop_one();
        send_frame(8'h3E, 1'b1, 1'b0, 1'b1, 1'b0);
        chk("R8 per-byte ferr", int'(rx_ferr), 1);
        chk("R8 data kept", int'(rx_data), 'h3E);
        chk("R8 sticky frame flag", int'(err_frame), 1);
        pop_one();
        clear_flags();
        chk("R11 frame flag cleared", int'(err_frame), 0);
        two_stop = 1'b1;
        send_frame(8'h42, 1'b1, 1'b1, 1'b0, 1'b1);
        chk("R8 second stop checked", int'(rx_ferr), 1);
        pop_one();
        send_frame(8'h43, 1'b1, 1'b1, 1'b1, 1'b1);
        chk("R3 two stops good", int'(rx_ferr), 0);
        chk("R3 two stops data", int'(rx_data), 'h43);
        pop_one();
        clear_flags();
        two_stop = 1'b0;
        for (int i = 0; i < 8; i++) send_frame(8'(8'h20 + i), 1'b1, 1'b1, 1'b1, 1'b0);
        chk("R10 queue full", int'(rx_full), 1);
        chk("R10 no overrun yet", int'(err_ovr), 0);
        send_frame(8'h99, 1'b1, 1'b1, 1'b1, 1'b0);
        chk("R10 overrun flag", int'(err_ovr), 1);
        for (int i = 0; i < 8; i++) begin
            chk("R10 contents kept", int'(rx_data), 'h20 + i);
            pop_one();
        end
        chk("R10 dropped byte absent", int'(rx_empty), 1);
        chk("R10 overrun flag sticky", int'(err_ovr), 1);
        clear_flags();
        chk("R11 overrun flag cleared", int'(err_ovr), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule